// File: doc/BRIEF.md
# Control-Word Parity Service Monitor

This block watches the parity check results of control words that arrive on a four-lane internal parallel bus and decides whether the link is in service. Each lane delivers one word per clock together with a valid bit, a control-word marker and the result of a parity check that was computed upstream. The block keeps two run counters. One counts consecutive failed checks while the link is in service, and the other counts consecutive passing checks while the link is out of service. Both counters handle all lanes of a cycle at once.

The out-of-service flag is raised when failed checks reach a programmable bad threshold. It is lowered after a programmable number of consecutive passing control words. While the flag is set, the block asks the status channel to send framing patterns to the neighbouring device. Payload reception is never gated by this block. The thresholds are static configuration, and a threshold of zero behaves like a threshold of one.

Top module: `dip4_svc_mon`

## Requirements
- R1: While `rst_n` is low, `oos` is 1. It stays 1 after reset is released until R2 clears it.
- R2: While out of service, passing control words add to a good count (several in one cycle add their number). When that count reaches `good_thresh`, `oos` drops to 0 at the following clock edge.
- R3: While in service, each failing control word adds one to a bad count. When the count reaches `bad_thresh`, `oos` rises at the following clock edge and both counts restart from zero.
- R4: While in service, a cycle that carries only passing control words resets the bad count to zero.
- R5: A lane takes part only when `lane_vld` is 1 and `lane_ctl` is 1. A lane that is a payload word (valid, marker 0) or invalid changes neither count nor the flag, whatever its `lane_ok` value.
- R6: While in service, a cycle that carries at least one passing and at least one failing control word resets the bad count and never raises `oos`.
- R7: `send_framing` equals `oos` in every cycle.
- R8: While in service, a cycle with k failing and no passing control words adds k to the bad count, so `oos` can rise from a single cycle.
- R9: While out of service, any failing control word resets the good count to zero.
- R10: A value of 0 on `bad_thresh` or `good_thresh` acts as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_vld | input | LANES (4) | Per-lane word present |
| lane_ctl | input | LANES (4) | Per-lane control-word marker |
| lane_ok | input | LANES (4) | Per-lane parity check passed |
| bad_thresh | input | CW (8) | Bad-check count that takes the link out of service |
| good_thresh | input | CW (8) | Good-check count that returns the link to service |
| oos | output | 1 | Out-of-service flag |
| send_framing | output | 1 | Request for the status channel to send framing |

## Verification
The bench sets up a mixed cycle right after two failed checks. A design that added the bad lane instead of clearing on the good lane would trip one word early. Other corners are several failing lanes in one cycle reaching the threshold at once, payload and invalid lanes carrying a failed parity bit, and a single bad word landing between good words while out of service. A design that counted per cycle rather than per word, or that let payload lanes count, would change the flag at the wrong cycle. Zero thresholds and long biased random sweeps over many threshold pairs, compared against an arithmetic model of the counts, catch off-by-one errors in the threshold comparison.

// File: rtl/dip4_svc_mon_pkg.sv
// Package: shared types and helpers for the control-word parity service monitor.
// Assumes thresholds are unsigned; zero is mapped to one by thr_eff.
package dip4_svc_mon_pkg;

    typedef enum logic {
        SVC_UP   = 1'b0,
        SVC_DOWN = 1'b1
    } svc_state_e;

    // Width needed to hold a count from 0 to n inclusive.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/dip4_lane_tally.sv
// Module: counts passing and failing control words across all lanes of one cycle.
// Assumes a lane counts only when both valid and control marker are high.
module dip4_lane_tally #(
    parameter int LANES = 4,
    parameter int NW    = dip4_svc_mon_pkg::cnt_width(LANES)
) (
    input  logic [LANES-1:0] lane_vld,
    input  logic [LANES-1:0] lane_ctl,
    input  logic [LANES-1:0] lane_ok,
    output logic [NW-1:0]    n_good,
    output logic [NW-1:0]    n_bad
);

    logic [LANES-1:0] good_l;
    logic [LANES-1:0] bad_l;

    // Per-lane classification of the word into passing or failing control word.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign good_l[i] = lane_vld[i] & lane_ctl[i] &  lane_ok[i];
        assign bad_l[i]  = lane_vld[i] & lane_ctl[i] & ~lane_ok[i];
    end

    // Population count of both classes over the lanes.
    always_comb begin
        n_good = '0;
        n_bad  = '0;
        for (int i = 0; i < LANES; i++) begin
            n_good = n_good + NW'(good_l[i]);
            n_bad  = n_bad  + NW'(bad_l[i]);
        end
    end

endmodule

// File: rtl/dip4_run_counter.sv
// Module: consecutive-event counter with threshold detection.
// Counts while active, clears on clear or when inactive, and flags hit when the
// running sum reaches the effective threshold (zero threshold acts as one).
// Assumes IW < CW + 1 so the increment fits the sum width.
module dip4_run_counter #(
    parameter int CW = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          clear,
    input  logic [IW-1:0] inc,
    input  logic [CW-1:0] thresh,
    output logic          hit,
    output logic [CW-1:0] cnt
);

    localparam int SW = CW + 1;

    logic [CW-1:0] thr_eff;
    logic [SW-1:0] sum;

    // Effective threshold and running sum for this cycle.
    always_comb begin
        thr_eff = (thresh == '0) ? CW'(1) : thresh;
        sum     = {1'b0, cnt} + {{(SW-IW){1'b0}}, inc};
        hit     = active && !clear && (inc != '0) && (sum >= {1'b0, thr_eff});
    end

    // Counter register: restart on inactivity, clear or threshold hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || clear || hit) begin
            cnt <= '0;
        end else begin
            cnt <= sum[CW-1:0];
        end
    end

endmodule

// File: rtl/dip4_svc_mon.sv
// Module: link service monitor driven by per-lane control-word parity results.
// A bad-run counter works while in service and a good-run counter while out of
// service; either reaching its threshold flips the service state. The state
// resets to out of service. Assumes thresholds change only during reset.
module dip4_svc_mon #(
    parameter int LANES = 4,
    parameter int CW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_vld,
    input  logic [LANES-1:0] lane_ctl,
    input  logic [LANES-1:0] lane_ok,
    input  logic [CW-1:0]    bad_thresh,
    input  logic [CW-1:0]    good_thresh,
    output logic             oos,
    output logic             send_framing
);

    import dip4_svc_mon_pkg::*;

    localparam int NW = cnt_width(LANES);

    svc_state_e    state_q;
    logic [NW-1:0] n_good;
    logic [NW-1:0] n_bad;
    logic          bad_hit;
    logic          good_hit;
    logic [CW-1:0] bad_cnt;
    logic [CW-1:0] good_cnt;

    dip4_lane_tally #(.LANES(LANES), .NW(NW)) u_tally (
        .lane_vld (lane_vld),
        .lane_ctl (lane_ctl),
        .lane_ok  (lane_ok),
        .n_good   (n_good),
        .n_bad    (n_bad)
    );

    // Bad run: counts in service, any passing word in the cycle clears it.
    dip4_run_counter #(.CW(CW), .IW(NW)) u_bad_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == SVC_UP),
        .clear  (n_good != '0),
        .inc    (n_bad),
        .thresh (bad_thresh),
        .hit    (bad_hit),
        .cnt    (bad_cnt)
    );

    // Good run: counts out of service, any failing word in the cycle clears it.
    dip4_run_counter #(.CW(CW), .IW(NW)) u_good_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == SVC_DOWN),
        .clear  (n_bad != '0),
        .inc    (n_good),
        .thresh (good_thresh),
        .hit    (good_hit),
        .cnt    (good_cnt)
    );

    // Service state register: resets out of service, flips on threshold hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SVC_DOWN;
        end else if (bad_hit) begin
            state_q <= SVC_DOWN;
        end else if (good_hit) begin
            state_q <= SVC_UP;
        end
    end

    // Output flags: framing request follows the out-of-service state.
    always_comb begin
        oos          = (state_q == SVC_DOWN);
        send_framing = oos;
    end

endmodule

// File: rtl/dip4_svc_mon_chk.sv
// Checker: temporal properties of the service monitor, bound to every instance.
// Assumes the same lane qualification as the monitor (valid and control marker).
module dip4_svc_mon_chk #(
    parameter int LANES = 4,
    parameter int CW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] lane_vld,
    input logic [LANES-1:0] lane_ctl,
    input logic [LANES-1:0] lane_ok,
    input logic [CW-1:0]    bad_thresh,
    input logic             oos,
    input logic [CW-1:0]    bad_cnt
);

    logic          good_any;
    logic          bad_any;
    logic [CW-1:0] bthr_eff;

    // Cycle-level view of the lanes and the effective bad threshold.
    always_comb begin
        good_any = |(lane_vld & lane_ctl &  lane_ok);
        bad_any  = |(lane_vld & lane_ctl & ~lane_ok);
        bthr_eff = (bad_thresh == '0) ? CW'(1) : bad_thresh;
    end

    assert_oos_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> oos);

    assert_clear_needs_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oos) |-> $past(good_any && !bad_any));

    assert_trip_needs_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oos) |-> $past(bad_any && !good_any));

    assert_bad_below_thr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !oos |-> (bad_cnt < bthr_eff));

    assert_payload_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!good_any && !bad_any) |=> $stable(oos));

    assert_mixed_no_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oos && good_any) |=> !oos);

endmodule

bind dip4_svc_mon dip4_svc_mon_chk #(.LANES(LANES), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_vld   (lane_vld),
    .lane_ctl   (lane_ctl),
    .lane_ok    (lane_ok),
    .bad_thresh (bad_thresh),
    .oos        (oos),
    .bad_cnt    (bad_cnt)
);

// File: tb/dip4_svc_mon_test.sv
// Bench: directed corner cases plus biased random sweeps over threshold pairs.
module dip4_svc_mon_test;

    localparam int LANES = 4;
    localparam int CW    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LANES-1:0] lane_vld = '0;
    logic [LANES-1:0] lane_ctl = '0;
    logic [LANES-1:0] lane_ok = '0;
    logic [CW-1:0]    bad_thresh = 8'd3;
    logic [CW-1:0]    good_thresh = 8'd2;
    logic             oos;
    logic             send_framing;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // 100 MHz clock.
    always #5 clk = ~clk;

    dip4_svc_mon #(.LANES(LANES), .CW(CW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_vld     (lane_vld),
        .lane_ctl     (lane_ctl),
        .lane_ok      (lane_ok),
        .bad_thresh   (bad_thresh),
        .good_thresh  (good_thresh),
        .oos          (oos),
        .send_framing (send_framing)
    );

    task automatic check(input string req, input logic exp);
        total++;
        if (oos !== exp || send_framing !== exp) begin
            bad++;
            $display("FAIL %s: oos=%b send_framing=%b expected %b at %0t",
                     req, oos, send_framing, exp, $time);
        end
    endtask

    // Drive one cycle of lanes, then sample 1 ns after the edge.
    task automatic apply(input logic [3:0] v, input logic [3:0] c, input logic [3:0] k);
        lane_vld = v;
        lane_ctl = c;
        lane_ok  = k;
        @(posedge clk);
        #1;
    endtask

    task automatic good1();  apply(4'b0001, 4'b0001, 4'b0001); endtask
    task automatic bad1();   apply(4'b0001, 4'b0001, 4'b0000); endtask
    task automatic idle1();  apply(4'b0000, 4'b0000, 4'b0000); endtask

    task automatic do_reset(input int bt, input int gt);
        rst_n = 1'b0;
        bad_thresh  = CW'(bt);
        good_thresh = CW'(gt);
        idle1();
        idle1();
        check("R1 during reset", 1'b1);
        rst_n = 1'b1;
        idle1();
        check("R1 after release", 1'b1);
    endtask

    // Biased random sweep against an arithmetic model of both counts.
    task automatic sweep(input int bt, input int gt, input int n);
        int mb = 0;
        int mg = 0;
        bit moos = 1;
        int be = (bt == 0) ? 1 : bt;
        int ge = (gt == 0) ? 1 : gt;
        do_reset(bt, gt);
        for (int cyc = 0; cyc < n; cyc++) begin
            logic [3:0] v = '0;
            logic [3:0] c = '0;
            logic [3:0] k = '0;
            int ng = 0;
            int nb = 0;
            int mode = int'($urandom % 4);
            for (int l = 0; l < LANES; l++) begin
                int r = int'($urandom % 8);
                if (mode == 1 && r >= 6) r = 3;
                if (mode == 2 && r >= 3 && r <= 5) r = 7;
                v[l] = (r != 0);
                c[l] = (r >= 3);
                k[l] = (r >= 3 && r <= 5) ? 1'b1 : ((r < 3) ? 1'($urandom % 2) : 1'b0);
                if (r == 0) c[l] = 1'($urandom % 2);
                if (r >= 3 && r <= 5) ng++;
                if (r >= 6) nb++;
            end
            if (!moos) begin
                if (ng > 0) mb = 0;
                else if (nb > 0) begin
                    if (mb + nb >= be) begin moos = 1; mb = 0; mg = 0; end
                    else mb = mb + nb;
                end
            end else begin
                if (nb > 0) mg = 0;
                else if (ng > 0) begin
                    if (mg + ng >= ge) begin moos = 0; mg = 0; mb = 0; end
                    else mg = mg + ng;
                end
            end
            apply(v, c, k);
            check("sweep R2 R3 R8 R9", moos);
        end
    endtask

    initial begin
        #1;
        do_reset(3, 2);
        idle1();
        idle1();
        check("R1 held with no control words", 1'b1);

        // R2: two passing words needed.
        good1();
        check("R2 one good not enough", 1'b1);
        good1();
        check("R2 second good clears", 1'b0);
        check("R7 framing off in service", 1'b0);

        // R3: three failing words trip.
        bad1();
        check("R3 bad 1", 1'b0);
        bad1();
        check("R3 bad 2", 1'b0);
        bad1();
        check("R3 bad 3 trips", 1'b1);
        check("R7 framing on when out of service", 1'b1);
        good1(); good1();
        check("R2 recover", 1'b0);

        // R4: a good word restarts the bad run.
        bad1(); bad1(); good1(); bad1(); bad1();
        check("R4 good reset the bad run", 1'b0);
        bad1();
        check("R4 third bad after reset trips", 1'b1);
        good1(); good1();

        // R5: payload and invalid lanes ignored, both in and out of service.
        bad1();
        apply(4'b0001, 4'b0000, 4'b0001);
        apply(4'b0000, 4'b1111, 4'b0000);
        apply(4'b0001, 4'b0000, 4'b0000);
        check("R5 payload and invalid between bads", 1'b0);
        bad1();
        check("R5 second bad", 1'b0);
        bad1();
        check("R5 run kept across payload trips", 1'b1);
        good1();
        apply(4'b1111, 4'b0000, 4'b0000);
        apply(4'b0000, 4'b1111, 4'b0000);
        check("R5 payload out of service holds flag", 1'b1);
        good1();
        check("R5 good run kept across payload", 1'b0);

        // R6: mixed cycle clears instead of adding.
        bad1(); bad1();
        apply(4'b0011, 4'b0011, 4'b0010);
        check("R6 mixed cycle no trip", 1'b0);
        bad1(); bad1();
        check("R6 bad count restarted", 1'b0);
        bad1();
        check("R6 third bad after mix trips", 1'b1);

        // R8: several words per cycle.
        apply(4'b0110, 4'b0110, 4'b0110);
        check("R8 two goods in one cycle clear", 1'b0);
        apply(4'b0111, 4'b0111, 4'b0000);
        check("R8 three bads in one cycle trip", 1'b1);
        apply(4'b1001, 4'b1001, 4'b1001);
        bad1();
        apply(4'b1010, 4'b1010, 4'b0000);
        check("R8 one plus two bads trip", 1'b1);
        good1(); good1();
        apply(4'b1100, 4'b1100, 4'b0000);
        check("R8 two bads below three", 1'b0);
        good1();

        // R9: a bad word out of service restarts the good run.
        bad1(); bad1(); bad1();
        check("R9 setup trip", 1'b1);
        good1(); bad1(); good1();
        check("R9 good run restarted", 1'b1);
        good1();
        check("R9 clears after two fresh goods", 1'b0);
        apply(4'b1111, 4'b1111, 4'b0000);
        apply(4'b0011, 4'b0011, 4'b0001);
        check("R9 mixed cycle out of service no clear", 1'b1);
        good1();
        check("R9 one good after mixed not enough", 1'b1);
        good1();
        check("R9 clear", 1'b0);

        // R10: zero thresholds act as one.
        do_reset(0, 0);
        good1();
        check("R10 zero good threshold", 1'b0);
        bad1();
        check("R10 zero bad threshold", 1'b1);

        // Sweeps over threshold pairs.
        for (int bt = 0; bt <= 5; bt++) begin
            for (int gt = 0; gt <= 3; gt++) begin
                sweep(bt, gt, 400);
            end
        end

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule